// File: doc/BRIEF.md
# Ring ORAM Operation Sequencer

This block decides, for one oblivious-memory controller, which tree operation goes out next. Logical requests arrive with their leaf label already looked up. Each one becomes a read-path descriptor for that leaf. After every fixed number of read-type descriptors the block inserts an eviction descriptor. Eviction paths advance through the leaves in reverse-lexicographic order: the path is the bit-reverse of a running eviction counter. As a result, two evictions in a row share as few buckets as possible.

The block watches the stash occupancy count. When the count reaches a high-water mark, the block stops taking real requests and pads with dummy read paths until the normal eviction point, then issues the eviction. It never issues an eviction early, so an observer sees the same read/evict rhythm. It keeps running such rounds until, at the acceptance of an eviction, the occupancy has dropped below the high-water mark minus a hysteresis margin. Descriptors leave on a valid/ready handshake and stay stable until they are accepted.

The control is a four-state machine. ST_IDLE waits. It moves to ST_DUMMY when pressure is present; otherwise it moves to ST_READ when a request is taken. ST_READ and ST_DUMMY present one read-type descriptor. On acceptance they move to ST_EVICT if that descriptor completed the interval, or back to ST_IDLE if it did not. ST_EVICT presents the eviction descriptor and returns to ST_IDLE on acceptance.

Top module: `oram_op_sequencer`

## Requirements
- R1: After reset, op_valid is 0, and req_ready is 1 while stash_count is below BG_HIGH.
- R2: A request taken on a clock edge with req_valid and req_ready high appears after that edge as a descriptor with op_kind 2'b01 (read path) and op_path equal to the request's leaf.
- R3: While op_valid is 1 and op_ready is 0, op_valid, op_kind and op_path stay unchanged on the next cycle.
- R4: After every EVICT_RATE accepted read-type descriptors (op_kind 2'b01 or 2'b10), the next descriptor is an eviction (op_kind 2'b11). No eviction is issued before that count is reached.
- R5: The n-th eviction (counting from 0 after reset) targets the path equal to the LEAF_BITS-bit bit-reverse of n. With LEAF_BITS=4 the sequence is 0, 8, 4, 12, and so on.
- R6: Whenever stash_count is at least BG_HIGH, req_ready is 0 in that same cycle. The block then issues dummy read paths (op_kind 2'b10) until the eviction count is reached, including real reads already issued in the current interval, and then issues the eviction.
- R7: Background mode continues for further dummy/evict rounds while stash_count is at least BG_HIGH-BG_HYST when an eviction is accepted. It ends at the acceptance of an eviction made while stash_count is below that value, after which real requests are taken again.
- R8: A dummy read descriptor targets the same path as the next eviction.
- R9: req_ready is 0 whenever a descriptor is outstanding (op_valid is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A logical request is offered |
| req_leaf | input | LEAF_BITS | Leaf label of the offered request |
| req_ready | output | 1 | Request is taken on this edge if req_valid |
| stash_count | input | $clog2(STASH_CAP+1) | Current stash occupancy in blocks |
| op_valid | output | 1 | Descriptor is presented |
| op_kind | output | 2 | 01 read path, 10 dummy read path, 11 eviction |
| op_path | output | LEAF_BITS | Target path of the descriptor |
| op_ready | input | 1 | Downstream accepts the descriptor on this edge |

## Verification
A wrong interval counter shows up at the ports within one interval. The eviction appears one descriptor too early or too late, and the bench checks the kind of every descriptor in order. A wrong eviction counter or bit-reversal changes op_path on the next eviction and also on every dummy read before it. A pressure flag stuck on or off shows at once: req_ready is high during pressure, a dummy appears where a real read was due, or real traffic does not resume after the exit eviction.

// File: rtl/oram_seq_pkg.sv
package oram_seq_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_DUMMY = 2'b10,
        OP_EVICT = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_DUMMY,
        ST_EVICT
    } seq_state_e;
endpackage

// File: rtl/oram_evict_path.sv
module oram_evict_path #(
    parameter int LEAF_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    output logic [LEAF_BITS-1:0] path
);
    logic [LEAF_BITS-1:0] evict_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)       evict_cnt <= '0;
        else if (advance) evict_cnt <= evict_cnt + 1'b1;
    end

    // reverse-lexicographic order: mirror the counter bits
    for (genvar b = 0; b < LEAF_BITS; b++) begin : g_rev
        assign path[b] = evict_cnt[LEAF_BITS-1-b];
    end
endmodule

// File: rtl/oram_pressure_mon.sv
module oram_pressure_mon #(
    parameter int STASH_CAP = 500,
    parameter int BG_HIGH   = 400,
    parameter int BG_HYST   = 50
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(STASH_CAP+1)-1:0] stash_count,
    input  logic                           round_done,
    output logic                           bg_now
);
    localparam int CNT_W  = $clog2(STASH_CAP+1);
    localparam int BG_LOW = BG_HIGH - BG_HYST;

    logic bg_q;
    logic over_high;
    logic under_low;

    assign over_high = stash_count >= CNT_W'(BG_HIGH);
    assign under_low = stash_count <  CNT_W'(BG_LOW);

    always_ff @(posedge clk) begin
        if (!rst_n)                       bg_q <= 1'b0;
        else if (over_high)               bg_q <= 1'b1;
        else if (round_done && under_low) bg_q <= 1'b0;
    end

    assign bg_now = bg_q | over_high;
endmodule

// File: rtl/oram_op_sequencer.sv
module oram_op_sequencer
    import oram_seq_pkg::*;
#(
    parameter int LEAF_BITS  = 4,
    parameter int EVICT_RATE = 3,
    parameter int STASH_CAP  = 500,
    parameter int BG_HIGH    = 400,
    parameter int BG_HYST    = 50
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [LEAF_BITS-1:0]           req_leaf,
    output logic                           req_ready,
    input  logic [$clog2(STASH_CAP+1)-1:0] stash_count,
    output logic                           op_valid,
    output logic [1:0]                     op_kind,
    output logic [LEAF_BITS-1:0]           op_path,
    input  logic                           op_ready
);
    localparam int RD_W = $clog2(EVICT_RATE + 1);

    seq_state_e           state, state_nx;
    logic [LEAF_BITS-1:0] leaf_q;
    logic [RD_W-1:0]      rd_cnt;
    logic [LEAF_BITS-1:0] evict_path;
    logic                 bg_now;
    logic                 evict_fire;
    logic                 rd_fire;
    logic                 req_fire;
    logic                 interval_full;

    assign req_fire      = req_valid && req_ready;
    assign rd_fire       = op_ready && (state == ST_READ || state == ST_DUMMY);
    assign evict_fire    = op_ready && (state == ST_EVICT);
    assign interval_full = rd_cnt == RD_W'(EVICT_RATE - 1);

    oram_evict_path #(.LEAF_BITS(LEAF_BITS)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (evict_fire),
        .path    (evict_path)
    );

    oram_pressure_mon #(
        .STASH_CAP (STASH_CAP),
        .BG_HIGH   (BG_HIGH),
        .BG_HYST   (BG_HYST)
    ) u_press (
        .clk         (clk),
        .rst_n       (rst_n),
        .stash_count (stash_count),
        .round_done  (evict_fire),
        .bg_now      (bg_now)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (bg_now)         state_nx = ST_DUMMY;
                else if (req_valid) state_nx = ST_READ;
            end
            ST_READ, ST_DUMMY: begin
                if (op_ready) state_nx = interval_full ? ST_EVICT : ST_IDLE;
            end
            ST_EVICT: begin
                if (op_ready) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            leaf_q <= '0;
            rd_cnt <= '0;
        end else begin
            state <= state_nx;
            if (req_fire) leaf_q <= req_leaf;
            if (rd_fire)  rd_cnt <= interval_full ? '0 : rd_cnt + 1'b1;
        end
    end

    always_comb begin
        op_valid  = 1'b1;
        op_kind   = OP_NONE;
        op_path   = evict_path;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                op_valid  = 1'b0;
                req_ready = !bg_now;
            end
            ST_READ: begin
                op_kind = OP_READ;
                op_path = leaf_q;
            end
            ST_DUMMY: op_kind = OP_DUMMY;
            ST_EVICT: op_kind = OP_EVICT;
            default:  op_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/oram_seq_checker.sv
module oram_seq_checker #(
    parameter int LEAF_BITS  = 4,
    parameter int EVICT_RATE = 3,
    parameter int STASH_CAP  = 500,
    parameter int BG_HIGH    = 400,
    parameter int BG_HYST    = 50
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_ready,
    input logic [$clog2(STASH_CAP+1)-1:0] stash_count,
    input logic                           op_valid,
    input logic [1:0]                     op_kind,
    input logic [LEAF_BITS-1:0]           op_path,
    input logic                           op_ready
);
    localparam int CW    = $clog2(EVICT_RATE + 1) + 1;
    localparam int CNT_W = $clog2(STASH_CAP + 1);

    logic [CW-1:0] reads_seen;
    logic          fire;
    assign fire = op_valid && op_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) reads_seen <= '0;
        else if (fire && op_kind == 2'b11) reads_seen <= '0;
        else if (fire) reads_seen <= reads_seen + 1'b1;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_path)); // R3
    AST_EVICT_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op_kind == 2'b11 |-> reads_seen == CW'(EVICT_RATE)); // R4
    AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op_kind != 2'b11 |-> reads_seen < CW'(EVICT_RATE)); // R4
    AST_HOLD_OFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stash_count >= CNT_W'(BG_HIGH) |-> !req_ready); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !req_ready); // R9
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_kind != 2'b00); // R2
endmodule

bind oram_op_sequencer oram_seq_checker #(
    .LEAF_BITS  (LEAF_BITS),
    .EVICT_RATE (EVICT_RATE),
    .STASH_CAP  (STASH_CAP),
    .BG_HIGH    (BG_HIGH),
    .BG_HYST    (BG_HYST)
) u_seq_chk (.*);

// File: tb/test_oram_op_sequencer.sv
module test_oram_op_sequencer;
    localparam int L     = 4;
    localparam int A     = 3;
    localparam int CAP   = 500;
    localparam int HIGH  = 400;
    localparam int HYST  = 50;
    localparam int CNT_W = $clog2(CAP + 1);

    // vector: [7:4] stall cycles before accept, [3:0] leaf
    localparam logic [7:0] VEC [0:5] = '{8'h05, 8'h29, 8'h0E, 8'h13, 8'h00, 8'h3F};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [L-1:0]     req_leaf = '0;
    logic             req_ready;
    logic [CNT_W-1:0] stash_count = '0;
    logic             op_valid;
    logic [1:0]       op_kind;
    logic [L-1:0]     op_path;
    logic             op_ready = 1'b0;

    int total = 0;
    int bad   = 0;
    int n_ev  = 0;

    always #4 clk = ~clk;

    oram_op_sequencer #(
        .LEAF_BITS(L), .EVICT_RATE(A), .STASH_CAP(CAP), .BG_HIGH(HIGH), .BG_HYST(HYST)
    ) i_oram_op_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_leaf(req_leaf),
        .req_ready(req_ready), .stash_count(stash_count), .op_valid(op_valid),
        .op_kind(op_kind), .op_path(op_path), .op_ready(op_ready)
    );

    function automatic logic [L-1:0] mirror(input int n);
        logic [L-1:0] v = L'(n);
        logic [L-1:0] r;
        for (int b = 0; b < L; b++) r[b] = v[L-1-b];
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [L-1:0] leaf);
        req_valid = 1'b1;
        req_leaf  = leaf;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take_op(input logic [1:0] kind, input logic [L-1:0] path,
                           input int stall, input string tag);
        logic [1:0]   k0;
        logic [L-1:0] p0;
        while (!op_valid) @(negedge clk);
        k0 = op_kind;
        p0 = op_path;
        chk({tag, " R9 req_ready while outstanding"}, int'(req_ready), 0);
        for (int s = 0; s < stall; s++) begin
            @(posedge clk);
            @(negedge clk);
            chk({tag, " R3 held valid"}, int'(op_valid), 1);
            chk({tag, " R3 held kind/path"}, int'({op_kind, op_path}), int'({k0, p0}));
        end
        chk({tag, " kind"}, int'(op_kind), int'(kind));
        chk({tag, " path"}, int'(op_path), int'(path));
        op_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_ready = 1'b0;
        if (kind == 2'b11) n_ev++;
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 op_valid in reset", int'(op_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 op_valid after reset", int'(op_valid), 0);
        chk("R1 req_ready after reset", int'(req_ready), 1);

        // table walk: real reads (R2) with eviction every A (R4) on mirrored paths (R5)
        for (int i = 0; i < 6; i++) begin
            send_req(VEC[i][3:0]);
            take_op(2'b01, VEC[i][3:0], int'(VEC[i][7:4]), "R2 read");
            if (i % A == A - 1) take_op(2'b11, mirror(n_ev), 1, "R4 R5 evict");
        end

        // one real read, then pressure arrives mid-interval
        send_req(4'd7);
        take_op(2'b01, 4'd7, 0, "R2 read before pressure");
        stash_count = CNT_W'(HIGH);
        req_valid   = 1'b1;
        req_leaf    = 4'd1;
        #1;
        chk("R6 req_ready low at threshold", int'(req_ready), 0);
        take_op(2'b10, mirror(n_ev), 0, "R6 R8 dummy");
        take_op(2'b10, mirror(n_ev), 1, "R6 R8 dummy");
        stash_count = CNT_W'(HIGH - 20);
        take_op(2'b11, mirror(n_ev), 0, "R6 R5 evict after padding");
        // still above low mark: another full round (R7)
        chk("R7 req_ready in continued round", int'(req_ready), 0);
        for (int d = 0; d < A; d++) take_op(2'b10, mirror(n_ev), 0, "R7 R8 dummy");
        stash_count = CNT_W'(HIGH - HYST - 1);
        take_op(2'b11, mirror(n_ev), 0, "R7 exit evict");
        chk("R7 req_ready after exit", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        take_op(2'b01, 4'd1, 0, "R7 held request served");

        repeat (2) @(negedge clk);
        chk("R1 idle after run", int'(op_valid), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule